// File: doc/BRIEF.md
# Translation Table Base Register Bank

This block keeps the configuration registers that tell an interrupt translation unit where its in-memory tables live. It holds a bank of 64-bit registers. Each register carries a read-only table type, a read-only entry size, an indirection bit that always reads as zero, and writable fields for the base address, the page size and the table size. Software reaches the bank through a simple register port. Each request is answered by a registered response on the next cycle.

A second port serves the translation logic. It presents a table type, and the block searches the bank for the register that carries that type. One cycle later the block returns that table's base address, already aligned to the register's page size, or it raises a miss flag. After reset, register 0 describes the device table and register 1 describes the collection table. All other registers are unimplemented and carry type 0.

Top module: `tbase_bank`

## Requirements
- R1: After reset, register 0 reads 0x0107_0000_0000_0000 (type 1 = device table, entry size 7). Register 1 reads 0x0407_0000_0000_0000 (type 4 = collection table, entry size 7). Registers 2 to 7 read zero. All outputs are low.
- R2: Bit 62 (indirection) of every register reads as zero, and writes to it have no effect.
- R3: The type field (bits 58:56) and the entry-size field (bits 52:48) never change on a write.
- R4: When a register's type is 0, bits 7:0 ignore writes. When the type is nonzero, bits 7:0 take the written value.
- R5: Every other bit takes the written value exactly, so a write can both set and clear it.
- R6: Register n sits at byte offset 8·n. A request with req_valid high gives rsp_valid high on the next cycle. A read returns the register value in rsp_rdata, and a write returns zero.
- R7: An access whose offset is at or beyond 8·NUM_REGS, or whose low three address bits are not zero, answers with rsp_err high and rsp_rdata zero. Such an access changes no register.
- R8: A lookup (lk_valid) gives lk_done on the next cycle. When a register holds the requested nonzero type, lk_miss is low and lk_addr holds that register's decoded base.
- R9: A lookup for type 0, or for a type that no register holds, gives lk_miss high and lk_addr zero.
- R10: The base address is register bits 47:12, with bits 11:0 zero. Page-size field bits 9:8 control further clearing. With 00 (4 KB) nothing more is cleared. With 01 (16 KB) bits 13:12 are cleared. With 10 (64 KB) or the reserved 11, bits 15:12 are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset into the bank |
| req_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_rdata | output | 64 | Read data (zero on writes and errors) |
| rsp_err | output | 1 | Bad offset or misaligned access |
| lk_valid | input | 1 | Lookup request |
| lk_type | input | 3 | Table type to search for |
| lk_done | output | 1 | Lookup result valid |
| lk_miss | output | 1 | No register carries the requested type |
| lk_addr | output | 48 | Decoded table base address |

## Verification
The bench writes all ones and then all zeros to every register. A design with a wrong write mask would let the type, entry-size or indirection bits move. It would also let the size byte of an unimplemented register change, or fail to clear writable bits. Misaligned and out-of-range offsets are mixed between valid writes, so a decoder that aliases them onto a real register would corrupt that register. Lookups cover each page-size code, including the reserved one, and request type 0 as well as absent types. A design that matched idle registers or cleared the wrong low bits would return a wrong address or no miss.

// File: rtl/tbase_pkg.sv
`timescale 1ns/1ps
package tbase_pkg;
  localparam int REG_W    = 64;
  localparam int ADR_W    = 48;
  localparam int IND_BIT  = 62;
  localparam int TYP_LO   = 56;
  localparam int TYP_HI   = 58;
  localparam int ESZ_LO   = 48;
  localparam int ESZ_HI   = 52;
  localparam int PGS_LO   = 8;
  localparam int PGS_HI   = 9;
  localparam int SZ_HI    = 7;

  typedef enum logic [2:0] {
    TT_NONE    = 3'd0,
    TT_DEVICE  = 3'd1,
    TT_COLLECT = 3'd4
  } ttype_e;

  typedef enum logic [1:0] {
    PG_4K  = 2'b00,
    PG_16K = 2'b01,
    PG_64K = 2'b10,
    PG_RSV = 2'b11
  } pgsz_e;

  localparam logic [REG_W-1:0] FIXED_BITS =
      (64'd1 << IND_BIT) | (64'd7 << TYP_LO) | (64'h1F << ESZ_LO);
  localparam logic [REG_W-1:0] SIZE_BITS = 64'hFF;

  function automatic logic [REG_W-1:0] writable_mask(input logic [2:0] typ);
    logic [REG_W-1:0] m;
    m = ~FIXED_BITS;
    if (typ == TT_NONE) m = m & ~SIZE_BITS;
    return m;
  endfunction

  function automatic logic [REG_W-1:0] reset_value(input int idx);
    logic [REG_W-1:0] v;
    v = '0;
    if (idx == 0) v = (64'(TT_DEVICE) << TYP_LO) | (64'd7 << ESZ_LO);
    else if (idx == 1) v = (64'(TT_COLLECT) << TYP_LO) | (64'd7 << ESZ_LO);
    return v;
  endfunction

  function automatic logic [ADR_W-1:0] decode_base(input logic [REG_W-1:0] r);
    logic [ADR_W-1:0] a;
    a = {r[ADR_W-1:12], 12'h000};
    case (pgsz_e'(r[PGS_HI:PGS_LO]))
      PG_4K:   a = a;
      PG_16K:  a[13:12] = 2'b00;
      default: a[15:12] = 4'h0;
    endcase
    return a;
  endfunction
endpackage

// File: rtl/tbase_regfile.sv
`timescale 1ns/1ps
module tbase_regfile
  import tbase_pkg::*;
#(
  parameter int NUM_REGS = 8,
  localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           wr_en,
  input  logic [IDX_W-1:0]               wr_idx,
  input  logic [REG_W-1:0]               wr_data,
  output logic [NUM_REGS-1:0][REG_W-1:0] bank
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic [REG_W-1:0] q;
    logic [REG_W-1:0] wmask;
    assign wmask = writable_mask(q[TYP_HI:TYP_LO]);
    always_ff @(posedge clk) begin
      if (rst) q <= reset_value(g);
      else if (wr_en && wr_idx == IDX_W'(g)) q <= (q & ~wmask) | (wr_data & wmask);
    end
    assign bank[g] = q;
  end
endmodule

// File: rtl/tbase_lookup.sv
`timescale 1ns/1ps
module tbase_lookup
  import tbase_pkg::*;
#(
  parameter int NUM_REGS = 8
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [NUM_REGS-1:0][REG_W-1:0] bank,
  input  logic                           lk_valid,
  input  logic [2:0]                     lk_type,
  output logic                           lk_done,
  output logic                           lk_miss,
  output logic [ADR_W-1:0]               lk_addr
);
  logic [NUM_REGS-1:0] hit;
  logic [REG_W-1:0]    sel;
  logic                found;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_cmp
    assign hit[g] = (bank[g][TYP_HI:TYP_LO] == lk_type) && (lk_type != TT_NONE);
  end

  // lowest-index match wins
  always_comb begin
    sel   = '0;
    found = 1'b0;
    for (int i = NUM_REGS - 1; i >= 0; i--) begin
      if (hit[i]) begin
        sel   = bank[i];
        found = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lk_done <= 1'b0;
      lk_miss <= 1'b0;
      lk_addr <= '0;
    end else begin
      lk_done <= lk_valid;
      lk_miss <= lk_valid && !found;
      lk_addr <= (lk_valid && found) ? decode_base(sel) : '0;
    end
  end
endmodule

// File: rtl/tbase_bank.sv
`timescale 1ns/1ps
module tbase_bank
  import tbase_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int ADDR_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [63:0]       req_wdata,
  output logic              rsp_valid,
  output logic [63:0]       rsp_rdata,
  output logic              rsp_err,
  input  logic              lk_valid,
  input  logic [2:0]        lk_type,
  output logic              lk_done,
  output logic              lk_miss,
  output logic [47:0]       lk_addr
);
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam logic [ADDR_W-1:0] BANK_END = ADDR_W'(NUM_REGS * 8);

  logic [NUM_REGS-1:0][REG_W-1:0] bank;
  logic [IDX_W-1:0]               idx;
  logic                           ok;
  logic                           wr_en;

  assign idx   = req_addr[IDX_W+2:3];
  assign ok    = (req_addr < BANK_END) && (req_addr[2:0] == 3'b000);
  assign wr_en = req_valid && req_write && ok;

  tbase_regfile #(.NUM_REGS(NUM_REGS)) u_rf (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_idx  (idx),
    .wr_data (req_wdata),
    .bank    (bank)
  );

  tbase_lookup #(.NUM_REGS(NUM_REGS)) u_lk (
    .clk      (clk),
    .rst      (rst),
    .bank     (bank),
    .lk_valid (lk_valid),
    .lk_type  (lk_type),
    .lk_done  (lk_done),
    .lk_miss  (lk_miss),
    .lk_addr  (lk_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_err   <= req_valid && !ok;
      rsp_rdata <= (req_valid && !req_write && ok) ? bank[idx] : '0;
    end
  end
endmodule

// File: rtl/tbase_bank_chk.sv
`timescale 1ns/1ps
module tbase_bank_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rsp_valid,
  input logic [63:0]       rsp_rdata,
  input logic              rsp_err,
  input logic              lk_valid,
  input logic [2:0]        lk_type,
  input logic              lk_done,
  input logic              lk_miss,
  input logic [47:0]       lk_addr
);
  a_r2_indirect_zero: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !rsp_rdata[62]);
  a_r6_rsp_follows: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  a_r6_write_zero: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write) |=> (rsp_rdata == 64'd0));
  a_r7_misaligned_err: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_addr[2:0] != 3'b000) |=> rsp_err);
  a_r7_err_zero: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> (rsp_valid && rsp_rdata == 64'd0));
  a_r8_lk_latency: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> lk_done);
  a_r8_lk_idle: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> !lk_done && !lk_miss);
  a_r9_type0_miss: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && lk_type == 3'd0) |=> lk_miss);
  a_r9_miss_addr: assert property (@(posedge clk) disable iff (rst)
    lk_miss |-> (lk_addr == 48'd0));
  a_r10_low_zero: assert property (@(posedge clk) disable iff (rst)
    lk_done |-> (lk_addr[11:0] == 12'd0));
endmodule

bind tbase_bank tbase_bank_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
  .rsp_err(rsp_err), .lk_valid(lk_valid), .lk_type(lk_type),
  .lk_done(lk_done), .lk_miss(lk_miss), .lk_addr(lk_addr)
);

// File: tb/tbase_bank_bench.sv
`timescale 1ns/1ps
module tbase_bank_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [63:0] req_wdata = '0;
  logic        rsp_valid, rsp_err;
  logic [63:0] rsp_rdata;
  logic        lk_valid = 1'b0;
  logic [2:0]  lk_type = '0;
  logic        lk_done, lk_miss;
  logic [47:0] lk_addr;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [63:0] mdl [8];

  always #2 clk = ~clk;

  tbase_bank u_tbase_bank (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .lk_valid(lk_valid),
    .lk_type(lk_type), .lk_done(lk_done), .lk_miss(lk_miss), .lk_addr(lk_addr)
  );

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic void model_reset();
    for (int i = 0; i < 8; i++) mdl[i] = 64'd0;
    mdl[0] = 64'h0107_0000_0000_0000;
    mdl[1] = 64'h0407_0000_0000_0000;
  endfunction

  task automatic cyc(input logic v, input logic w, input logic [7:0] a, input logic [63:0] d,
                     input logic lv, input logic [2:0] lt, input string tag);
    logic [63:0] e_rd, keep, e_la;
    logic        e_err, e_lm, ok, hit;
    int          idx;
    req_valid = v; req_write = w; req_addr = a; req_wdata = d;
    lk_valid = lv; lk_type = lt;
    @(posedge clk);
    ok = (a < 8'd64) && (a % 8 == 0);
    idx = a / 8;
    e_err = v && !ok;
    e_rd = (v && !w && ok) ? mdl[idx % 8] : 64'd0;
    hit = 0; e_la = 0;
    if (lv && lt != 0)
      for (int i = 7; i >= 0; i--)
        if (mdl[i][58:56] == lt) begin hit = 1; e_la = mdl[i]; end
    if (hit) begin
      e_la = e_la & 64'h0000_FFFF_FFFF_F000;
      if (e_la[9:8] == 2'b01 || mdl[0] == 0) e_la = e_la;
    end
    if (hit) begin
      logic [63:0] src;
      src = 0;
      for (int i = 7; i >= 0; i--) if (mdl[i][58:56] == lt) src = mdl[i];
      if (src[9:8] == 2'b01) e_la = e_la & ~64'h3000;
      else if (src[9:8] != 2'b00) e_la = e_la & ~64'hF000;
    end
    e_lm = lv && !hit;
    if (v && w && ok) begin
      keep = 64'h4000_0000_0000_0000 | 64'h0700_0000_0000_0000 | 64'h001F_0000_0000_0000;
      if (mdl[idx][58:56] == 3'd0) keep = keep | 64'hFF;
      mdl[idx] = (mdl[idx] & keep) | (d & ~keep);
    end
    #1;
    chk(tag, "rsp_valid", 64'(rsp_valid), 64'(v));
    chk(tag, "rsp_err",   64'(rsp_err),   64'(e_err));
    chk(tag, "rsp_rdata", rsp_rdata,      e_rd);
    chk(tag, "lk_done",   64'(lk_done),   64'(lv));
    chk(tag, "lk_miss",   64'(lk_miss),   64'(e_lm));
    chk(tag, "lk_addr",   64'(lk_addr),   e_la);
  endtask

  task automatic rd(input logic [7:0] a, input string tag);
    cyc(1, 0, a, 64'd0, 0, 3'd0, tag);
  endtask
  task automatic wr(input logic [7:0] a, input logic [63:0] d, input string tag);
    cyc(1, 1, a, d, 0, 3'd0, tag);
  endtask
  task automatic lk(input logic [2:0] t, input string tag);
    cyc(0, 0, 8'd0, 64'd0, 1, t, tag);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] lf;
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    cyc(0, 0, 8'd0, 64'd0, 0, 3'd0, "R1 idle");
    for (int i = 0; i < 8; i++) rd(8'(i * 8), "R1 R6 reset read");
    lk(3'd1, "R8 device");
    lk(3'd4, "R8 collection");
    for (int i = 0; i < 8; i++) wr(8'(i * 8), 64'hFFFF_FFFF_FFFF_FFFF, "R3 R4 ones");
    for (int i = 0; i < 8; i++) rd(8'(i * 8), "R2 R3 R4 readback");
    for (int i = 0; i < 8; i++) wr(8'(i * 8), 64'd0, "R5 zeros");
    for (int i = 0; i < 8; i++) rd(8'(i * 8), "R4 R5 readback");
    wr(8'd0, 64'h4000_0000_0000_0000, "R2 indirect");
    rd(8'd0, "R2 readback");
    wr(8'd8, 64'h0000_1234_5678_9AA5, "R5 pattern");
    wr(8'd9, 64'hFFFF_FFFF_FFFF_FFFF, "R7 misaligned");
    wr(8'd64, 64'hFFFF_FFFF_FFFF_FFFF, "R7 range");
    wr(8'd252, 64'hFFFF_FFFF_FFFF_FFFF, "R7 range hi");
    rd(8'd12, "R7 misaligned read");
    rd(8'd200, "R7 range read");
    rd(8'd8, "R7 unchanged");
    rd(8'd16, "R7 unchanged");
    wr(8'd0, 64'h0000_ABCD_EF12_F000, "R10 4K");
    lk(3'd1, "R10 4K");
    wr(8'd0, 64'h0000_ABCD_EF12_F100, "R10 16K");
    lk(3'd1, "R10 16K");
    wr(8'd0, 64'h0000_ABCD_EF12_F200, "R10 64K");
    lk(3'd1, "R10 64K");
    wr(8'd0, 64'h0000_ABCD_EF12_F300, "R10 rsvd");
    lk(3'd1, "R10 rsvd");
    lk(3'd4, "R8 collection base");
    for (int t = 0; t < 8; t++) if (t != 1 && t != 4) lk(3'(t), "R9 absent");
    lf = 64'hACE1_2468_1357_9BDF;
    for (int i = 0; i < 200; i++) begin
      lf = {lf[62:0], lf[63] ^ lf[62] ^ lf[60] ^ lf[59]};
      cyc(lf[0], lf[1], {lf[9:8], lf[5:3], (lf[2] & lf[6]) ? lf[12:10] : 3'b000},
          {lf[31:0], lf[63:32]}, lf[13], lf[16:14], "R6 R8 mixed");
    end
    cyc(0, 0, 8'd0, 64'd0, 0, 3'd0, "R8 idle");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule